// File: doc/BRIEF.md
# Credit-Based Transmit Shaper

This block shapes the traffic of a single transmit queue. It holds a signed credit value that decides when the queue may start a frame. The credit grows at the idle rate while a frame is waiting or while the credit is below zero. It shrinks at the send rate while one of the queue's frames is on the wire. Two programmed bounds, a ceiling and a floor, keep it within range. The queue scheduler reads `tx_allow` before it picks this queue.

Software scales the values before it writes them. Each slope register holds the requested slope ×1024 × rate factor ÷ speed divider. At 100 Mb/s the rate factor is 4 and the divider is 100000; at 1 Gb/s they are 8 and 1000000. The send register is computed from the negated send slope, so it holds a positive magnitude. Each limit register holds the requested credit ×8192, truncated to the register width, in two's complement. Credit changes once per byte-time. That interval is a fixed number of core clocks, picked by the link-speed input.

The queue's position comes from a parameter. Queue 0 can never be shaped. Any other queue is shaped only while `shape_en` is high. When `shape_en` is low the queue runs in its plain default mode.

Top module: `cbs_shaper`

## Requirements
- R1: After reset the credit is zero and `tx_allow` is 1.
- R2: While `shape_en` is 0, `tx_allow` is 1 and the credit is forced to zero, so that shaping always restarts from zero credit.
- R3: With `QUEUE_NUM` = 0, `tx_allow` is 1 whatever the other inputs do.
- R4: While shaping, the credit changes only on a byte-time tick. A tick falls every `TICK_DIV_GBPS` clocks when `link_gbps` = 1 and every `TICK_DIV_MBPS` clocks when it is 0. The tick divider restarts when shaping is switched on. Between ticks the credit holds.
- R5: On a tick with `frame_sending` = 0, the credit grows by `idle_slope` if `frame_waiting` = 1 or the credit is negative.
- R6: On a tick with `frame_sending` = 1, the credit falls by `send_slope`, which is treated as an unsigned magnitude.
- R7: A tick never leaves the credit above `hi_limit`, a signed two's complement value.
- R8: A tick never leaves the credit below `lo_limit`, a signed two's complement value.
- R9: On a tick with no frame waiting, no frame sending and the credit at zero or above, the credit becomes zero.
- R10: While shaping, `tx_allow` is 1 when the credit is zero or above, or when `frame_sending` = 1. The second case means a frame already on the wire is never cut off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shape_en | input | 1 | 1 selects shaped mode, 0 selects the default mode |
| link_gbps | input | 1 | 1 for a 1 Gb/s link, 0 for a 100 Mb/s link |
| idle_slope | input | SLOPE_W | Scaled credit gain per tick |
| send_slope | input | SLOPE_W | Scaled credit loss per tick (positive magnitude) |
| hi_limit | input | CREDIT_W | Credit ceiling (signed, ×8192) |
| lo_limit | input | CREDIT_W | Credit floor (signed, ×8192) |
| frame_waiting | input | 1 | The queue holds a frame |
| frame_sending | input | 1 | A frame from the queue is being transmitted |
| tx_allow | output | 1 | The queue may start or continue a frame |

## Verification
The bench drives the credit into the ceiling first and then sends. A shaper without the ceiling would keep the queue open for an extra tick. Next the credit is held at the floor. Without the floor, recovery would take longer and `tx_allow` would come back late. The bench also empties the queue while the credit is positive and then sends once. If the shaper failed to zero the credit, `tx_allow` would stay high after that single send. The remaining checks cover four cases: a frame continuing while the credit is negative, the slower tick spacing at 100 Mb/s, a restart from zero after shaping is switched off, and a queue-0 instance. A shaper that wrongly gated or shaped in any of these cases would block the queue.

// File: rtl/cbs_shaper.sv
module cbs_shaper #(
  parameter int QUEUE_NUM     = 1,
  parameter int CREDIT_W      = 32,
  parameter int SLOPE_W       = 32,
  parameter int TICK_DIV_GBPS = 2,
  parameter int TICK_DIV_MBPS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shape_en,
  input  logic                link_gbps,
  input  logic [SLOPE_W-1:0]  idle_slope,
  input  logic [SLOPE_W-1:0]  send_slope,
  input  logic [CREDIT_W-1:0] hi_limit,
  input  logic [CREDIT_W-1:0] lo_limit,
  input  logic                frame_waiting,
  input  logic                frame_sending,
  output logic                tx_allow
);

  localparam bit SHAPEABLE = (QUEUE_NUM != 0);
  localparam int XW        = CREDIT_W + 2;
  localparam int PADW      = XW - SLOPE_W;
  localparam int DIV_MAX   = (TICK_DIV_GBPS > TICK_DIV_MBPS) ? TICK_DIV_GBPS : TICK_DIV_MBPS;
  localparam int CNTW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNTW-1:0] LIM_GBPS = CNTW'(TICK_DIV_GBPS - 1);
  localparam logic [CNTW-1:0] LIM_MBPS = CNTW'(TICK_DIV_MBPS - 1);

  logic                 active;
  logic                 tick;
  logic [CNTW-1:0]      cnt_q;
  logic [CNTW-1:0]      cnt_lim;
  logic [CREDIT_W-1:0]  credit_q;
  logic signed [XW-1:0] cr_x, hi_x, lo_x, up_x, dn_x, raw_x, clip_x;

  assign active  = SHAPEABLE && shape_en;
  assign cnt_lim = link_gbps ? LIM_GBPS : LIM_MBPS;
  assign tick    = active && (cnt_q >= cnt_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cr_x = {{2{credit_q[CREDIT_W-1]}}, credit_q};
  assign hi_x = {{2{hi_limit[CREDIT_W-1]}}, hi_limit};
  assign lo_x = {{2{lo_limit[CREDIT_W-1]}}, lo_limit};
  assign up_x = cr_x + $signed({{PADW{1'b0}}, idle_slope});
  assign dn_x = cr_x - $signed({{PADW{1'b0}}, send_slope});

  always_comb begin
    if (frame_sending)                            raw_x = dn_x;
    else if (frame_waiting || credit_q[CREDIT_W-1]) raw_x = up_x;
    else                                          raw_x = '0;
    if (raw_x > hi_x)      clip_x = hi_x;
    else if (raw_x < lo_x) clip_x = lo_x;
    else                   clip_x = raw_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       credit_q <= '0;
    else if (!active) credit_q <= '0;
    else if (tick)    credit_q <= clip_x[CREDIT_W-1:0];
  end

  assign tx_allow = !active || !credit_q[CREDIT_W-1] || frame_sending;

endmodule

module cbs_shaper_chk #(
  parameter int QUEUE_NUM = 1,
  parameter int CREDIT_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       active,
  input logic                       tick,
  input logic signed [CREDIT_W-1:0] credit,
  input logic signed [CREDIT_W-1:0] hi_limit,
  input logic signed [CREDIT_W-1:0] lo_limit,
  input logic                       frame_waiting,
  input logic                       frame_sending,
  input logic                       tx_allow
);
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n) active && !tick |=> $stable(credit)); // R4
  AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !active |=> credit == '0); // R2
  AST_UPPER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) active && tick |=> credit <= $past(hi_limit)); // R7
  AST_LOWER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) active && tick |=> credit >= $past(lo_limit)); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) active && tick && !frame_waiting && !frame_sending && credit >= 0 |=> credit == '0); // R9
  AST_NO_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n) frame_sending |-> tx_allow); // R10
  AST_QUEUE0_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (QUEUE_NUM == 0) |-> tx_allow); // R3
endmodule

bind cbs_shaper cbs_shaper_chk #(.QUEUE_NUM(QUEUE_NUM), .CREDIT_W(CREDIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .credit(credit_q),
  .hi_limit(hi_limit), .lo_limit(lo_limit), .frame_waiting(frame_waiting),
  .frame_sending(frame_sending), .tx_allow(tx_allow)
);

// File: tb/test_cbs_shaper.sv
`timescale 1ns/100ps
module test_cbs_shaper;
  localparam int CW = 32;
  localparam int SW = 32;
  localparam int DG = 2;
  localparam int DM = 5;

  typedef struct { bit exp; string tag; } item_t;

  logic clk = 0, rst_n = 0;
  logic shape_en = 0, link_gbps = 1, frame_waiting = 0, frame_sending = 0;
  logic [SW-1:0] idle_slope = 10, send_slope = 30;
  logic [CW-1:0] hi_limit = 50, lo_limit = -60;
  logic tx_allow, tx_allow_q0;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t sb[$];
  item_t sb0[$];
  longint m_cr = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  cbs_shaper #(.QUEUE_NUM(1), .CREDIT_W(CW), .SLOPE_W(SW), .TICK_DIV_GBPS(DG), .TICK_DIV_MBPS(DM)) i_cbs_shaper (
    .clk(clk), .rst_n(rst_n), .shape_en(shape_en), .link_gbps(link_gbps),
    .idle_slope(idle_slope), .send_slope(send_slope), .hi_limit(hi_limit), .lo_limit(lo_limit),
    .frame_waiting(frame_waiting), .frame_sending(frame_sending), .tx_allow(tx_allow));

  cbs_shaper #(.QUEUE_NUM(0), .CREDIT_W(CW), .SLOPE_W(SW), .TICK_DIV_GBPS(DG), .TICK_DIV_MBPS(DM)) i_cbs_shaper_q0 (
    .clk(clk), .rst_n(rst_n), .shape_en(shape_en), .link_gbps(link_gbps),
    .idle_slope(idle_slope), .send_slope(send_slope), .hi_limit(hi_limit), .lo_limit(lo_limit),
    .frame_waiting(frame_waiting), .frame_sending(frame_sending), .tx_allow(tx_allow_q0));

  task automatic step(input bit en, input bit gb, input bit wt, input bit sd, input string tag);
    item_t it;
    item_t it0;
    bit tk;
    longint raw;
    @(negedge clk);
    shape_en = en; link_gbps = gb; frame_waiting = wt; frame_sending = sd;
    it.exp = !en || (m_cr >= 0) || sd;
    it.tag = tag;
    sb.push_back(it);
    it0.exp = 1'b1;
    it0.tag = "R3";
    sb0.push_back(it0);
    if (!en) begin
      m_cr = 0; m_cnt = 0;
    end else begin
      tk = (m_cnt >= (gb ? DG : DM) - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk) begin
        if (sd) raw = m_cr - longint'(send_slope);
        else if (wt || m_cr < 0) raw = m_cr + longint'(idle_slope);
        else raw = 0;
        if (raw > longint'($signed(hi_limit))) raw = longint'($signed(hi_limit));
        else if (raw < longint'($signed(lo_limit))) raw = longint'($signed(lo_limit));
        m_cr = raw;
      end
    end
  endtask

  task automatic run(input int n, input bit en, input bit gb, input bit wt, input bit sd, input string tag);
    for (int i = 0; i < n; i++) step(en, gb, wt, sd, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (tx_allow !== it.exp) begin
          errors++;
          $display("FAIL %s tx_allow actual=%0b expected=%0b at %0t", it.tag, tx_allow, it.exp, $time);
        end
      end
      if (sb0.size() > 0) begin
        item_t it;
        it = sb0.pop_front();
        checks++;
        if (tx_allow_q0 !== it.exp) begin
          errors++;
          $display("FAIL %s queue0 tx_allow actual=%0b expected=%0b at %0t", it.tag, tx_allow_q0, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #1;
    checks++;
    if (tx_allow !== 1'b1) begin
      errors++;
      $display("FAIL R1 tx_allow in reset actual=%0b expected=1", tx_allow);
    end
    #20;
    @(negedge clk) rst_n = 1;
    run(2, 0, 1, 1, 1, "R1");
    run(16, 1, 1, 1, 0, "R5");
    run(4, 1, 1, 1, 1, "R6");
    run(2, 1, 1, 1, 0, "R7");
    run(12, 1, 1, 1, 1, "R10");
    run(20, 1, 1, 1, 0, "R8");
    run(4, 1, 1, 0, 0, "R9");
    run(2, 1, 1, 1, 1, "R9");
    run(3, 1, 1, 0, 0, "R9");
    run(8, 1, 1, 0, 0, "R9");
    run(30, 1, 0, 1, 0, "R4");
    run(12, 1, 0, 1, 1, "R4");
    run(25, 1, 0, 1, 0, "R4");
    run(6, 1, 1, 1, 1, "R2");
    run(4, 0, 1, 1, 1, "R2");
    run(4, 1, 1, 0, 0, "R2");
    run(2, 1, 1, 1, 1, "R2");
    run(3, 1, 1, 0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule